// File: doc/BRIEF.md
# Scheduler Tick Timer

The block produces the periodic interrupt an operating-system scheduler runs on. A free-running divider gives a one-clock enable every 16 system clocks. On each enable a 20-bit interval counter steps up. When it reaches the programmed interval it returns to zero on that same enable. The same step sets a sticky pending flag and bumps a 12-bit tally of elapsed intervals. If software is late and misses ticks, the tally still shows how many intervals have passed.

Software reaches the block through a small register port: a write strobe, a read strobe, a 2-bit address and a 32-bit data word. The configuration word holds the interval field and two bits, one that runs the counter and one that lets the pending flag reach the interrupt line. The status word holds the pending flag and the tally, and reading it clears both. A third word returns the tally and the live counter value and clears nothing. The interrupt line is level-sensitive and registered.

Top module: `sched_tick_timer`

## Requirements
- R1: After a synchronous reset, irq is 0, and the CONFIG, STATUS and PEEK words all read 0.
- R2: While the counter runs, it advances by exactly one every 16 clocks. The divider runs freely from reset.
- R3: CONFIG[19:0] holds the interval field V. A running counter counts 0..V and then returns to 0, so it rolls over exactly once every 16×(V+1) clocks. V=0 rolls over on every divider enable.
- R4: Each rollover sets the pending flag and increments the tally by one.
- R5: CONFIG[25] is the interrupt enable. irq goes high one clock after pending is set while the enable is 1, and irq stays 0 while the enable is 0, even with pending set.
- R6: Reading address 1 (STATUS) returns pending in bit 31 and the tally in bits [11:0], then clears both. If a rollover falls in the same clock as the read, pending stays 1 and the tally becomes 1.
- R7: The tally wraps from 4095 to 0.
- R8: CONFIG[24] is the run bit. When it is cleared, the counter keeps counting up to its next rollover, and that rollover is counted. After that the counter holds at 0.
- R9: If the counter is already at or above a newly written interval field, it rolls over on the next divider enable.
- R10: Writes to address 1 or address 2 have no effect. Reading address 2 (PEEK) returns the tally in [31:20] and the counter in [19:0], and clears nothing.
- R11: Read data and rd_valid appear one clock after the clock that samples rd_en. Address 0 is CONFIG.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 CONFIG, 1 STATUS, 2 PEEK |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | High for one clock when rdata carries a read result |
| irq | output | 1 | Level interrupt to the interrupt controller |

## Verification
The bench sets up a status read that lands in exactly the clock of a rollover. A design that lets the clear win would drop that tick and return a tally one too small. It measures the spacing between interrupt edges for two interval values; an off-by-one compare would shift each spacing by 16 clocks. It steps the tally through 4095 to catch a counter that saturates or loses its wrap. It also drops the run bit in mid-interval. A design that stopped at once, or never stopped, would leave a nonzero counter value or a tally other than one.

// File: rtl/stt_pkg.sv
package stt_pkg;
  typedef enum logic [1:0] {
    REG_CFG    = 2'd0,
    REG_STATUS = 2'd1,
    REG_PEEK   = 2'd2
  } reg_sel_e;

  localparam int unsigned RUN_BIT  = 24;
  localparam int unsigned IE_BIT   = 25;
  localparam int unsigned PEND_BIT = 31;
endpackage

// File: rtl/stt_prescaler.sv
module stt_prescaler #(
  parameter int unsigned PRESCALE = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  generate
    if (PRESCALE > 1) begin : g_div
      logic [PW-1:0] phase;
      always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else if (phase == PW'(PRESCALE - 1)) phase <= '0;
        else phase <= phase + 1'b1;
      end
      assign tick = (phase == PW'(PRESCALE - 1));
    end else begin : g_pass
      assign tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/stt_interval_counter.sv
module stt_interval_counter #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run_en,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic active;

  // keeps going after run_en drops until it is back at zero
  assign active = run_en || (cnt != '0);
  assign wrap   = tick && active && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (tick && active) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/stt_tally.sv
module stt_tally #(
  parameter int unsigned TALLY_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc,
  input  logic               clr,
  output logic [TALLY_W-1:0] tally
);
  always_ff @(posedge clk) begin
    if (rst) tally <= '0;
    else if (clr && inc) tally <= TALLY_W'(1);
    else if (clr) tally <= '0;
    else if (inc) tally <= tally + 1'b1;
  end
endmodule

// File: rtl/stt_regfile.sv
module stt_regfile
  import stt_pkg::*;
#(
  parameter int unsigned CNT_W   = 20,
  parameter int unsigned TALLY_W = 12,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               wrap,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [TALLY_W-1:0] tally,
  output logic [CNT_W-1:0]   cfg_limit,
  output logic               cfg_run,
  output logic               cfg_ie,
  output logic               status_rd,
  output logic               pending,
  output logic [DATA_W-1:0]  rdata,
  output logic               rd_valid,
  output logic               irq
);
  localparam int unsigned PEEK_W = CNT_W + TALLY_W;

  logic [DATA_W-1:0] rd_mux;
  reg_sel_e          sel;

  assign sel       = reg_sel_e'(addr);
  assign status_rd = rd_en && (sel == REG_STATUS);

  always_comb begin
    rd_mux = '0;
    case (sel)
      REG_CFG: begin
        rd_mux[CNT_W-1:0] = cfg_limit;
        rd_mux[RUN_BIT]   = cfg_run;
        rd_mux[IE_BIT]    = cfg_ie;
      end
      REG_STATUS: begin
        rd_mux[TALLY_W-1:0] = tally;
        rd_mux[PEND_BIT]    = pending;
      end
      REG_PEEK: rd_mux[PEEK_W-1:0] = {tally, cnt};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_limit <= '0;
      cfg_run   <= 1'b0;
      cfg_ie    <= 1'b0;
      pending   <= 1'b0;
      rdata     <= '0;
      rd_valid  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (wr_en && (sel == REG_CFG)) begin
        cfg_limit <= wdata[CNT_W-1:0];
        cfg_run   <= wdata[RUN_BIT];
        cfg_ie    <= wdata[IE_BIT];
      end
      if (wrap) pending <= 1'b1;
      else if (status_rd) pending <= 1'b0;
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
      irq <= pending && cfg_ie;
    end
  end
endmodule

// File: rtl/sched_tick_timer.sv
module sched_tick_timer #(
  parameter int unsigned PRESCALE = 16,
  parameter int unsigned CNT_W    = 20,
  parameter int unsigned TALLY_W  = 12,
  parameter int unsigned DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic              irq
);
  logic               tick;
  logic               wrap;
  logic [CNT_W-1:0]   cnt;
  logic [TALLY_W-1:0] tally;
  logic [CNT_W-1:0]   cfg_limit;
  logic               cfg_run;
  logic               cfg_ie;
  logic               status_rd;
  logic               pending;

  stt_prescaler #(.PRESCALE(PRESCALE)) u_div (
    .clk(clk), .rst(rst), .tick(tick)
  );

  stt_interval_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .run_en(cfg_run),
    .limit(cfg_limit), .cnt(cnt), .wrap(wrap)
  );

  stt_tally #(.TALLY_W(TALLY_W)) u_tally (
    .clk(clk), .rst(rst), .inc(wrap), .clr(status_rd), .tally(tally)
  );

  stt_regfile #(.CNT_W(CNT_W), .TALLY_W(TALLY_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .wrap(wrap), .cnt(cnt), .tally(tally),
    .cfg_limit(cfg_limit), .cfg_run(cfg_run), .cfg_ie(cfg_ie),
    .status_rd(status_rd), .pending(pending), .rdata(rdata),
    .rd_valid(rd_valid), .irq(irq)
  );
endmodule

// File: rtl/sched_tick_timer_chk.sv
module sched_tick_timer_chk
  import stt_pkg::*;
#(
  parameter int unsigned PRESCALE = 16,
  parameter int unsigned CNT_W    = 20,
  parameter int unsigned TALLY_W  = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               rd_en,
  input logic [1:0]         addr,
  input logic               rd_valid,
  input logic               irq,
  input logic               tick,
  input logic               wrap,
  input logic [CNT_W-1:0]   cnt,
  input logic               run_en,
  input logic               irq_en,
  input logic               pending,
  input logic [TALLY_W-1:0] tally
);
  localparam int unsigned GW = $clog2(PRESCALE + 1) + 1;

  logic [GW-1:0] gap;
  logic          st_rd;

  assign st_rd = rd_en && (addr == REG_STATUS);

  always_ff @(posedge clk) begin
    if (rst || tick) gap <= '0;
    else gap <= gap + 1'b1;
  end

  // R2: divider enables are spaced PRESCALE clocks apart
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap == GW'(PRESCALE - 1)));

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !wrap && (run_en || cnt != '0)) |=> (cnt == $past(cnt) + 1'b1));

  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));

  // R4 and R7: tally steps by one, modulo its width
  a_r4_tally_step: assert property (@(posedge clk) disable iff (rst)
    (wrap && !st_rd) |=> (tally == $past(tally) + 1'b1));

  a_r5_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);

  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (st_rd && !wrap) |=> (!pending && tally == '0));

  a_r6_rollover_wins: assert property (@(posedge clk) disable iff (rst)
    wrap |=> pending);

  a_r8_hold_zero: assert property (@(posedge clk) disable iff (rst)
    (!run_en && cnt == '0) |=> (cnt == '0));

  a_r11_valid: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  a_r11_no_valid: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
endmodule

bind sched_tick_timer sched_tick_timer_chk #(
  .PRESCALE(PRESCALE), .CNT_W(CNT_W), .TALLY_W(TALLY_W)
) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rd_valid(rd_valid),
  .irq(irq), .tick(tick), .wrap(wrap), .cnt(cnt), .run_en(cfg_run),
  .irq_en(cfg_ie), .pending(pending), .tally(tally)
);

// File: tb/sched_tick_timer_test.sv
module sched_tick_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_CFG = 2'd0, A_ST = 2'd1, A_PK = 2'd2;
  localparam logic [31:0] M_ALL = 32'hFFFF_FFFF;
  localparam logic [31:0] M_ST  = 32'h8000_0FFF;
  localparam logic [31:0] M_TAL = 32'hFFF0_0000;
  localparam logic [31:0] M_CNT = 32'h000F_FFFF;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic rd_valid, irq;
  int checks = 0, fails = 0;
  int cyc = 0;
  logic [31:0] mon_last = '0;
  logic [31:0] q_exp[$], q_mask[$];
  string q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sched_tick_timer uut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .irq(irq));

  function automatic logic [31:0] cfgw(int v, bit run, bit ie);
    return {6'd0, ie, run, 4'd0, v[19:0]};
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results and compares them
  always @(posedge clk) begin
    #1;
    if (!rst && rd_valid) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R11 unexpected rd_valid", rdata, 0);
      end else begin
        logic [31:0] e, m;
        string t;
        e = q_exp.pop_front(); m = q_mask.pop_front(); t = q_tag.pop_front();
        mon_last = rdata;
        if (m != 0) check((rdata & m) == (e & m), t, rdata & m, e & m);
      end
    end
  end

  task automatic do_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(logic [1:0] a, logic [31:0] e, logic [31:0] m,
                         string tag, output logic [31:0] got);
    @(negedge clk); rd_en = 1'b1; addr = a;
    q_exp.push_back(e); q_mask.push_back(m); q_tag.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
    got = mon_last;
  endtask

  task automatic wait_irq(logic lvl, string tag);
    int n = 0;
    while (irq !== lvl && n < 20000) begin @(negedge clk); n++; end
    check(irq === lvl, tag, irq, lvl);
  endtask

  task automatic clear_low();
    logic [31:0] g;
    for (int k = 0; k < 3; k++) begin
      do_read(A_ST, 0, 0, "", g);
      repeat (3) @(negedge clk);
      if (irq == 1'b0) break;
    end
  endtask

  task automatic measure(int v, int exp_gap, string tag);
    logic [31:0] g;
    int t1, t2;
    do_write(A_CFG, cfgw(v, 1, 1));
    clear_low();
    wait_irq(1'b1, tag); t1 = cyc;
    do_read(A_ST, 32'h8000_0001, M_ST, "R4 status after first rollover", g);
    wait_irq(1'b0, "R6 irq drops after status read");
    wait_irq(1'b1, tag); t2 = cyc;
    check((t2 - t1) == exp_gap, tag, t2 - t1, exp_gap);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] g, a;
    int w, prev, steps_bad, iter;
    bit seen_wrap;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(irq == 1'b0, "R1 irq after reset", irq, 0);
    check(rd_valid == 1'b0, "R11 idle rd_valid", rd_valid, 0);
    do_read(A_CFG, 0, M_ALL, "R1 CONFIG reset", g);
    do_read(A_ST, 0, M_ALL, "R1 STATUS reset", g);
    do_read(A_PK, 0, M_ALL, "R1 PEEK reset", g);

    // R2: one step per 16 clocks
    do_write(A_CFG, cfgw(1000, 1, 0));
    repeat (100) @(negedge clk);
    do_read(A_PK, 0, 0, "", a);
    repeat (14) @(negedge clk);
    do_read(A_PK, a + 1, M_CNT, "R2 counter step over 16 clocks", g);

    // R9: shrink interval below current count
    repeat (400) @(negedge clk);
    do_write(A_CFG, cfgw(9, 1, 0));
    repeat (20) @(negedge clk);
    do_read(A_PK, 32'h0010_0000, M_TAL, "R9 early rollover tally", g);
    check(g[19:0] <= 9, "R9 counter within new interval", g[19:0], 9);

    // R3: period measurement
    measure(9, 160, "R3 period V=9");
    measure(3, 64, "R3 period V=3");

    // R5: interrupt enable gating
    do_write(A_CFG, cfgw(3, 1, 0));
    clear_low();
    repeat (200) @(negedge clk);
    check(irq == 1'b0, "R5 irq masked", irq, 0);
    do_read(A_PK, 0, 0, "", g);
    check(g[31:20] != 0, "R4 tally counts while masked", g[31:20], 1);
    do_write(A_CFG, cfgw(3, 1, 1));
    repeat (3) @(negedge clk);
    check(irq == 1'b1, "R5 irq after enable with pending", irq, 1);

    // R6: status read coinciding with a rollover (V=0)
    do_write(A_CFG, cfgw(0, 1, 1));
    clear_low();
    wait_irq(1'b1, "R3 V=0 rollover");
    w = cyc - 1;
    while (cyc != w + 7) @(negedge clk);
    do_read(A_ST, 0, 0, "", g);
    while (cyc != w + 46) @(negedge clk);
    do_read(A_ST, 32'h8000_0002, M_ST, "R6 read in rollover clock returns old tally", g);
    do_read(A_PK, 32'h0010_0000, M_TAL, "R6 rollover wins over clear", g);
    check(irq == 1'b1, "R6 pending kept irq high", irq, 1);

    // R7: tally wrap
    do_read(A_ST, 0, 0, "", g);
    prev = -1; steps_bad = 0; seen_wrap = 0; iter = 0;
    while (!seen_wrap && iter < 12000) begin
      int t;
      do_read(A_PK, 0, 0, "", g);
      t = int'(g[31:20]);
      if (prev >= 0 && t != prev && t != ((prev + 1) % 4096)) steps_bad++;
      if (prev == 4095 && t == 0) seen_wrap = 1;
      prev = t; iter++;
      repeat (6) @(negedge clk);
    end
    check(steps_bad == 0, "R7 tally steps by one", steps_bad, 0);
    check(seen_wrap, "R7 tally wraps 4095 to 0", seen_wrap, 1);

    // R8: run bit cleared mid-interval
    do_write(A_CFG, cfgw(99, 1, 0));
    do_read(A_ST, 0, 0, "", g);
    repeat (500) @(negedge clk);
    do_read(A_PK, 0, 0, "", a);
    check(a[19:0] > 0, "R8 counter running", a[19:0], 1);
    do_write(A_CFG, cfgw(99, 0, 0));
    repeat (40) @(negedge clk);
    do_read(A_PK, 0, 0, "", g);
    check(g[19:0] > a[19:0], "R8 counter continues after run cleared", g[19:0], a[19:0]);
    repeat (2000) @(negedge clk);
    do_read(A_PK, 32'h0010_0000, M_ALL, "R8 stopped at zero after one rollover", g);
    repeat (2000) @(negedge clk);
    do_read(A_PK, 32'h0010_0000, M_ALL, "R8 holds zero; R10 peek does not clear", g);

    // R10: writes to status and peek ignored
    do_write(A_ST, 32'h0000_0000);
    do_write(A_PK, 32'hFFFF_FFFF);
    do_read(A_CFG, cfgw(99, 0, 0), M_ALL, "R10 CONFIG untouched", g);
    do_read(A_PK, 32'h0010_0000, M_ALL, "R10 PEEK untouched", g);
    do_read(A_ST, 32'h8000_0001, M_ALL, "R10 STATUS untouched", g);
    do_read(A_ST, 0, M_ALL, "R6 STATUS cleared by read", g);

    repeat (4) @(negedge clk);
    check(q_exp.size() == 0, "R11 every read answered", q_exp.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule